// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the bus-facing half of a small serial NOR memory model. It watches a chip select, a serial clock and one data input, and from them decodes an 8-bit command, an optional 24-bit address, any dummy byte and any data bytes. Read commands stream bytes from a behavioural byte array held inside the block. The data output can carry one bit per clock, or two bits per clock when the input pin is turned around to act as a second output.

Commands that change the memory or its status are not carried out here. Each program data byte is passed on as a staging write. When chip select goes high, the whole command is handed over as a single request pulse to a separate protection and status unit, and it is handed over only if the command ended on a complete byte. That unit also owns the memory write port and supplies the status byte.

All pins are sampled with the block clock, which must run several times faster than the serial clock. Commands and data bytes arrive most significant bit first, and addresses arrive as three bytes, most significant byte first.

Top module: `sflash_front`

## Requirements
- R1: After reset the block responds only once it has seen a high-to-low transition on `cs_n`. If `cs_n` is already low when reset ends, clocking in bytes produces no output enable and no request.
- R2: Both serial clock idle levels are accepted: low at selection (mode 0) and high at selection (mode 3). Input bits are taken on rising `sck` edges.
- R3: Opcode 0x03 takes three address bytes and then returns array bytes MSB first on `io1_out`. The returned bytes start at the address, modulo the array size, and step upward, wrapping at the end of the array. Output bits change only after falling `sck` edges.
- R4: Opcode 0x0B behaves like 0x03, except that one dummy byte follows the address before data starts.
- R5: Opcode 0x3B takes the address and one dummy byte, then returns two bits per clock. `io1_out` carries the upper bit of each pair and `io0_out` the lower bit. `io0_oe` is high only in this data phase, and `io1_oe` is high in every read data phase.
- R6: Opcode 0x02 with an address and N≥1 data bytes gives one `stg_we` pulse per byte. The staging address keeps the upper 16 address bits and steps the low byte with wrap inside its 256-byte page. On deselect the block issues a request with kind 3 and length min(N,256).
- R7: Erase opcodes issue requests only with exactly four bytes (opcode plus address): 0x20 gives kind 4, 0x52 gives kind 5 and 0xD8 gives kind 6. Opcode 0xC7 sent alone gives kind 7. Any other byte count gives no request.
- R8: Opcode 0x06 sent alone gives kind 0, and 0x04 sent alone gives kind 1. Opcode 0x01 followed by exactly one byte gives kind 2, with that byte on `req_data`. Opcode 0x05 returns `status_in` repeatedly.
- R9: If `cs_n` rises with a partial byte received, no request is issued.
- R10: After 0xB9 sent alone, every opcode except 0xAB is ignored (no data, no request). Opcode 0xAB ends this state.
- R11: While deselected, neither output enable is asserted. `req_valid` and `stg_we` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| io0_in | input | 1 | Serial data in (lower data line) |
| io0_out | output | 1 | Lower bit of a pair in dual read |
| io0_oe | output | 1 | Drive enable for the lower data line |
| io1_out | output | 1 | Serial data out (upper data line) |
| io1_oe | output | 1 | Drive enable for the upper data line |
| status_in | input | 8 | Status byte supplied by the protection unit |
| mem_we | input | 1 | Array write strobe from the protection unit |
| mem_waddr | input | AW | Array write address |
| mem_wdata | input | 8 | Array write data |
| stg_we | output | 1 | Program data byte staging pulse |
| stg_addr | output | 24 | Staging byte address |
| stg_data | output | 8 | Staging byte value |
| req_valid | output | 1 | Request pulse at deselect |
| req_kind | output | 3 | 0 wr-enable, 1 wr-disable, 2 status write, 3 program, 4 4K erase, 5 32K erase, 6 64K erase, 7 full erase |
| req_addr | output | 24 | Address of the request |
| req_data | output | 8 | Status write value |
| req_len | output | PW+1 | Number of program bytes |

## Verification
The bench goes after framing errors. A chip select that rises one bit short of a byte must not issue an erase, which a design that counts only clocks would still do. An erase with one extra byte is also rejected. A select that is already low at reset must be ignored, where a level-sensitive design would decode it. Reads are checked in both clock modes. Bytes are taken from the end of the array so that a missing address wrap returns the wrong byte, and the dual phase is checked for swapped bit pairs. A 258-byte program must cap its length at 256 and wrap its staging address back to the page start. A deep power-down that only blocked reads would still leak a write-enable request, and the bench checks for that.

// File: rtl/sflash_front.sv
module sflash_front #(
  parameter int AW = 11,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          io0_in,
  output logic          io0_out,
  output logic          io0_oe,
  output logic          io1_out,
  output logic          io1_oe,
  input  logic [7:0]    status_in,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata,
  output logic          stg_we,
  output logic [23:0]   stg_addr,
  output logic [7:0]    stg_data,
  output logic          req_valid,
  output logic [2:0]    req_kind,
  output logic [23:0]   req_addr,
  output logic [7:0]    req_data,
  output logic [PW:0]   req_len
);
  localparam int DEPTH = 1 << AW;
  localparam logic [PW:0] PAGE_BYTES = {1'b1, {PW{1'b0}}};
  localparam logic [7:0] OP_READ = 8'h03, OP_FREAD = 8'h0B, OP_DREAD = 8'h3B,
                         OP_PROG = 8'h02, OP_SE = 8'h20, OP_BE32 = 8'h52,
                         OP_BE64 = 8'hD8, OP_CE = 8'hC7, OP_WREN = 8'h06,
                         OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_WRSR = 8'h01,
                         OP_SLEEP = 8'hB9, OP_WAKE = 8'hAB;

  function automatic logic [3:0] hdr_len(input logic [7:0] o);
    case (o)
      OP_READ:            return 4'd4;
      OP_FREAD, OP_DREAD: return 4'd5;
      OP_RDSR:            return 4'd1;
      default:            return 4'd0;
    endcase
  endfunction

  logic [7:0]    mem [DEPTH];
  logic          cs_s, cs_d, sck_s, sck_d, si_s;
  logic          sel, dpd, dph;
  logic [2:0]    bitc, ob;
  logic [3:0]    nbyte;
  logic [6:0]    sh;
  logic [7:0]    op, wsr;
  logic [23:0]   addr;
  logic [AW-1:0] raddr;
  logic [PW-1:0] pofs;
  logic [PW:0]   plen;
  logic          go;
  logic [2:0]    kind;

  wire cs_fall  = cs_d & ~cs_s;
  wire cs_rise  = ~cs_d & cs_s;
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire [7:0]  byte_in = {sh, si_s};
  wire [23:0] addr_n  = {addr[15:0], byte_in};
  wire [7:0]  op_n    = (nbyte != 4'd0) ? op :
                        (dpd && byte_in != OP_WAKE) ? 8'h00 : byte_in;
  wire        dual    = (op == OP_DREAD);
  wire [7:0]  rd_byte = (op == OP_RDSR) ? status_in : mem[raddr];

  assign io1_oe = sel & dph;
  assign io0_oe = sel & dph & dual;

  always_ff @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;

  always_comb begin
    go = 1'b0;
    kind = 3'd0;
    case (op)
      OP_WREN: begin go = (nbyte == 4'd1); kind = 3'd0; end
      OP_WRDI: begin go = (nbyte == 4'd1); kind = 3'd1; end
      OP_WRSR: begin go = (nbyte == 4'd2); kind = 3'd2; end
      OP_PROG: begin go = (nbyte >= 4'd5); kind = 3'd3; end
      OP_SE:   begin go = (nbyte == 4'd4); kind = 3'd4; end
      OP_BE32: begin go = (nbyte == 4'd4); kind = 3'd5; end
      OP_BE64: begin go = (nbyte == 4'd4); kind = 3'd6; end
      OP_CE:   begin go = (nbyte == 4'd1); kind = 3'd7; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_s, cs_d, sck_s, sck_d, si_s} <= '0;
      {sel, dpd, dph} <= '0;
      bitc <= '0; ob <= '0; nbyte <= '0; sh <= '0; op <= '0; wsr <= '0;
      addr <= '0; raddr <= '0; pofs <= '0; plen <= '0;
      io0_out <= 1'b0; io1_out <= 1'b0;
      stg_we <= 1'b0; stg_addr <= '0; stg_data <= '0;
      req_valid <= 1'b0; req_kind <= '0; req_addr <= '0; req_data <= '0; req_len <= '0;
    end else begin
      cs_s <= cs_n; cs_d <= cs_s; sck_s <= sck; sck_d <= sck_s; si_s <= io0_in;
      stg_we <= 1'b0;
      req_valid <= 1'b0;
      if (cs_fall) begin
        sel <= 1'b1; dph <= 1'b0; bitc <= '0; nbyte <= '0; plen <= '0; op <= '0;
      end else if (cs_rise) begin
        sel <= 1'b0;
        dph <= 1'b0;
        if (sel && bitc == 3'd0) begin
          if (go) begin
            req_valid <= 1'b1; req_kind <= kind; req_addr <= addr;
            req_data <= wsr; req_len <= plen;
          end
          if (op == OP_SLEEP && nbyte == 4'd1) dpd <= 1'b1;
          if (op == OP_WAKE && nbyte != 4'd0) dpd <= 1'b0;
        end
      end else if (sel) begin
        if (sck_rise) begin
          bitc <= bitc + 3'd1;
          sh <= byte_in[6:0];
          if (bitc == 3'd7) begin
            nbyte <= (nbyte == 4'hF) ? nbyte : nbyte + 4'd1;
            op <= op_n;
            if (nbyte == 4'd1) wsr <= byte_in;
            if (nbyte >= 4'd1 && nbyte <= 4'd3) addr <= addr_n;
            if (nbyte == 4'd3) pofs <= addr_n[PW-1:0];
            if (op == OP_PROG && nbyte >= 4'd4) begin
              stg_we <= 1'b1;
              stg_addr <= {addr[23:PW], pofs};
              stg_data <= byte_in;
              pofs <= pofs + 1'b1;
              if (plen != PAGE_BYTES) plen <= plen + 1'b1;
            end
            if (hdr_len(op_n) != 4'd0 && nbyte + 4'd1 == hdr_len(op_n)) begin
              dph <= 1'b1;
              ob <= '0;
              raddr <= (nbyte == 4'd3) ? addr_n[AW-1:0] : addr[AW-1:0];
            end
          end
        end
        if (sck_fall && dph) begin
          if (dual) begin
            io1_out <= rd_byte[{~ob[1:0], 1'b1}];
            io0_out <= rd_byte[{~ob[1:0], 1'b0}];
            ob <= {1'b0, ob[1:0] + 2'd1};
            if (ob[1:0] == 2'd3) raddr <= raddr + 1'b1;
          end else begin
            io1_out <= rd_byte[~ob];
            ob <= ob + 3'd1;
            if (ob == 3'd7) raddr <= raddr + 1'b1;
          end
        end
      end
    end
  end
endmodule

module sflash_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic io0_oe,
  input logic io1_oe,
  input logic io0_out,
  input logic io1_out,
  input logic req_valid,
  input logic stg_we,
  input logic dpd,
  input logic sck_fall
);
  p_pair_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> io1_oe);
  p_io1_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(io1_out));
  p_io0_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(io0_out));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (!io1_oe && !io0_oe));
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  p_stg_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stg_we |=> !stg_we);
  p_sleep_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |-> !req_valid);
endmodule

bind sflash_front sflash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io0_oe(io0_oe), .io1_oe(io1_oe),
  .io0_out(io0_out), .io1_out(io1_out), .req_valid(req_valid), .stg_we(stg_we),
  .dpd(dpd), .sck_fall(sck_fall)
);

// File: tb/sflash_front_bench.sv
module sflash_front_bench;
  localparam int DEPTH = 2048;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, io0_in = 1'b0;
  logic io0_out, io0_oe, io1_out, io1_oe;
  logic [7:0] status_in = 8'hA5;
  logic mem_we = 1'b0;
  logic [10:0] mem_waddr = '0;
  logic [7:0] mem_wdata = '0;
  logic stg_we, req_valid;
  logic [23:0] stg_addr, req_addr;
  logic [7:0] stg_data, req_data;
  logic [2:0] req_kind;
  logic [8:0] req_len;
  int tests = 0, fails = 0, nreq = 0, nstg = 0;
  logic [2:0] lk; logic [23:0] la; logic [7:0] ld; logic [8:0] ll;
  logic [23:0] sa [512];
  logic [7:0] sd [512];

  always #5 clk = ~clk;

  sflash_front u_sflash_front (.*);

  always @(negedge clk) begin
    if (req_valid) begin nreq++; lk = req_kind; la = req_addr; ld = req_data; ll = req_len; end
    if (stg_we) begin sa[nstg % 512] = stg_addr; sd[nstg % 512] = stg_data; nstg++; end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + a / 32 + 11);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic slot(input logic b, output logic o1, output logic o0);
    @(negedge clk); sck = 1'b0; io0_in = b;
    repeat (4) @(negedge clk);
    o1 = io1_out; o0 = io0_out;
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic o1, o0;
    for (int i = 7; i >= 0; i--) slot(b[i], o1, o0);
  endtask

  task automatic recv(input logic dual, output logic [7:0] d);
    logic o1, o0;
    d = '0;
    if (dual) for (int i = 0; i < 4; i++) begin slot(1'b0, o1, o0); d = {d[5:0], o1, o0}; end
    else      for (int i = 0; i < 8; i++) begin slot(1'b0, o1, o0); d = {d[6:0], o1}; end
  endtask

  task automatic sel_on(input logic m3);
    @(negedge clk); sck = m3; cs_n = 1'b1;
    repeat (4) @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off(input logic m3);
    @(negedge clk); sck = m3;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] o, input int nb, input logic [23:0] a);
    sel_on(1'b0); send(o);
    if (nb >= 4) begin send(a[23:16]); send(a[15:8]); send(a[7:0]); end
    if (nb == 5) send(8'h00);
    sel_off(1'b0);
  endtask

  localparam logic [32:0] RV [6] = '{
    {1'b0, 8'h03, 24'h000010}, {1'b1, 8'h03, 24'h0007FE},
    {1'b0, 8'h0B, 24'h000123}, {1'b1, 8'h0B, 24'h00A400},
    {1'b0, 8'h3B, 24'h000040}, {1'b1, 8'h3B, 24'h0007FF}
  };

  initial begin
    logic [7:0] d;
    logic o1, o0;
    int b;
    repeat (5) @(negedge clk);
    chk("R11 reset io1_oe", io1_oe, 0);
    chk("R11 reset io0_oe", io0_oe, 0);
    chk("R11 reset req_valid", req_valid, 0);
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); mem_we = 1'b1; mem_waddr = 11'(a); mem_wdata = pat(a);
    end
    @(negedge clk); mem_we = 1'b0;

    b = nreq;
    send(8'h03); send(8'h00); send(8'h00); send(8'h10);
    slot(1'b0, o1, o0);
    chk("R1 low-at-reset select ignored", io1_oe, 0);
    send(8'h06);
    @(negedge clk); sck = 1'b0; repeat (4) @(negedge clk);
    cs_n = 1'b1; repeat (8) @(negedge clk);
    chk("R1 no request before first fall", nreq - b, 0);

    for (int v = 0; v < 6; v++) begin
      automatic logic m3 = RV[v][32];
      automatic logic [7:0] o = RV[v][31:24];
      automatic logic [23:0] a = RV[v][23:0];
      automatic logic dual = (o == 8'h3B);
      automatic string r = (o == 8'h03) ? "R3 read" : (o == 8'h0B) ? "R4 fast read" : "R5 dual read";
      sel_on(m3);
      send(o); send(a[23:16]); send(a[15:8]); send(a[7:0]);
      if (o != 8'h03) send(8'h00);
      for (int k = 0; k < 3; k++) begin
        recv(dual, d);
        chk($sformatf("%s R2 mode%0d byte%0d", r, m3 ? 3 : 0, k), d, pat((int'(a) + k) % DEPTH));
      end
      chk({r, " R5 io0_oe"}, io0_oe, dual);
      chk({r, " io1_oe"}, io1_oe, 1);
      sel_off(m3);
      chk("R11 deselected oe", io1_oe | io0_oe, 0);
    end

    b = nreq; cmd(8'h06, 1, 0);
    chk("R8 wren count", nreq - b, 1); chk("R8 wren kind", lk, 0);
    b = nreq; cmd(8'h04, 1, 0);
    chk("R8 wrdi count", nreq - b, 1); chk("R8 wrdi kind", lk, 1);
    b = nreq; sel_on(1'b1); send(8'h01); send(8'h9C); sel_off(1'b1);
    chk("R8 wrsr count", nreq - b, 1); chk("R8 wrsr kind", lk, 2); chk("R8 wrsr data", ld, 8'h9C);
    sel_on(1'b0); send(8'h05); recv(1'b0, d); chk("R8 status byte0", d, 8'hA5);
    recv(1'b0, d); chk("R8 status byte1", d, 8'hA5); sel_off(1'b0);

    b = nreq; cmd(8'h20, 4, 24'h012345);
    chk("R7 sector erase kind", lk, 4); chk("R7 sector erase addr", la, 24'h012345);
    cmd(8'h52, 4, 24'h018000); chk("R7 32K erase kind", lk, 5);
    cmd(8'hD8, 4, 24'h020000); chk("R7 64K erase kind", lk, 6);
    cmd(8'hC7, 1, 0); chk("R7 chip erase kind", lk, 7);
    chk("R7 erase count", nreq - b, 4);
    b = nreq; cmd(8'h20, 5, 24'h001000);
    chk("R7 erase with extra byte ignored", nreq - b, 0);

    b = nreq; sel_on(1'b0); send(8'h06); slot(1'b0, o1, o0); slot(1'b0, o1, o0); slot(1'b1, o1, o0); sel_off(1'b0);
    chk("R9 partial byte wren", nreq - b, 0);
    b = nreq; sel_on(1'b0); send(8'h20); send(8'h00); send(8'h10);
    for (int i = 0; i < 7; i++) slot(1'b0, o1, o0);
    sel_off(1'b0);
    chk("R9 erase short by one bit", nreq - b, 0);

    b = nreq; begin
      automatic int s = nstg;
      sel_on(1'b0); send(8'h02); send(8'h00); send(8'h03); send(8'hFE);
      send(8'h11); send(8'h22); send(8'h33); sel_off(1'b0);
      chk("R6 stage count", nstg - s, 3);
      chk("R6 stage addr0", sa[s % 512], 24'h0003FE);
      chk("R6 stage addr2 page wrap", sa[(s + 2) % 512], 24'h000300);
      chk("R6 stage data2", sd[(s + 2) % 512], 8'h33);
      chk("R6 program kind", lk, 3); chk("R6 program addr", la, 24'h0003FE);
      chk("R6 program len", ll, 3); chk("R6 program count", nreq - b, 1);
      s = nstg;
      sel_on(1'b1); send(8'h02); send(8'h00); send(8'h05); send(8'h00);
      for (int i = 0; i < 258; i++) send(8'(i));
      sel_off(1'b1);
      chk("R6 long stage count", nstg - s, 258);
      chk("R6 long stage wrap addr", sa[(s + 256) % 512], 24'h000500);
      chk("R6 long stage wrap data", sd[(s + 257) % 512], 8'h01);
      chk("R6 length capped", ll, 9'd256);
    end

    cmd(8'hB9, 1, 0);
    b = nreq; cmd(8'h06, 1, 0);
    chk("R10 wren ignored asleep", nreq - b, 0);
    sel_on(1'b0); send(8'h03); send(8'h00); send(8'h00); send(8'h10); slot(1'b0, o1, o0);
    chk("R10 read ignored asleep", io1_oe, 0); sel_off(1'b0);
    cmd(8'hAB, 1, 0);
    b = nreq; cmd(8'h06, 1, 0);
    chk("R10 wren after wake", nreq - b, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule